// File: doc/BRIEF.md
# Reset Cause Recorder with Start Address Select

This block gathers every reset request in the device, turns them into one stretched internal reset, and records which sources caused it. There is a separate sticky flag for each of six sources: the external reset pin, power-on, supply brownout, watchdog, software and a break detected on the serial receive line. Software reads the flags after start-up to learn why the device restarted, and clears any of them by writing a zero to its bit.

Power-on and watchdog resets start the flags afresh. Every other reset adds its own flag to those already held. The block also chooses where execution begins once reset is released. It picks a boot page, made from an 8-bit vector as the high byte and 00h as the low byte, in three cases: the most recent reset came from a serial break, a non-volatile boot-status bit is set, or an in-system-programming request was seen while the device powered up. In every other case execution starts at 0000h. During power-up the external pin always works as a reset input. After that, it works as one only when its enable input is high.

Top module: `reset_cause_unit`

## Requirements
- R1: The flag vector holds one bit per source, at these positions: bit 0 external pin, bit 1 power-on, bit 2 brownout, bit 3 watchdog, bit 4 software, bit 5 serial break.
- R2: A power-on event (the block's own reset `rst_n` low, or a `por_req` pulse) leaves the flags at 06h: power-on and brownout set, all others cleared.
- R3: A watchdog event leaves the flags at 0Eh: power-on, brownout and watchdog set, all others cleared. It takes priority over any other source that is active in the same cycle.
- R4: A pin, brownout, software or break event sets its own flag and keeps every flag already set.
- R5: A write with `flag_wr_en` high clears each flag whose `flag_wr_data` bit is 0 and leaves each flag whose bit is 1 unchanged, so a write never sets a flag. When a write and a new event land in the same cycle, the event's flag ends up set.
- R6: The external pin is active low. It counts as a reset request when `pin_rst_en` is high, or during the power-up phase, which runs from a power-on event until `core_rst` first falls. At any other time a low pin changes neither the flags nor `core_rst`.
- R7: Every request passes through 2 synchronising flops. `core_rst` goes high on the clock edge after the synchronised request appears, which is the third edge after the request is first sampled. It stays high until HOLD_CYCLES (16) edges have passed after the last edge that saw an active request. After `rst_n` is released it is high for HOLD_CYCLES cycles.
- R8: `start_addr` is {`boot_vec`, 8'h00} when the most recent reset event was a serial break, when `boot_stat` is 1, or when the ISP latch of R9 is set. Otherwise it is 16'h0000. A later non-break reset ends the break case.
- R9: If `isp_force` is high at the power-on event or at any time during the power-up phase, the ISP latch is set, and it stays set until the next power-on event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block; treated as a power-on event |
| ext_rst_n_pin | input | 1 | External reset pin, active low |
| pin_rst_en | input | 1 | Lets the pin act as a reset input after power-up |
| por_req | input | 1 | Power-on request pulse from the supply monitor |
| bod_req | input | 1 | Brownout request pulse |
| wdt_req | input | 1 | Watchdog request pulse |
| sw_req | input | 1 | Software reset request pulse |
| brk_req | input | 1 | Serial break reset request pulse |
| boot_stat | input | 1 | Non-volatile boot-status bit |
| isp_force | input | 1 | In-system-programming force indication |
| boot_vec | input | 8 | High byte of the boot page address |
| flag_wr_en | input | 1 | Flag register write strobe |
| flag_wr_data | input | 6 | Write data; a 0 bit clears the matching flag |
| core_rst | output | 1 | Stretched internal reset, active high |
| flags | output | 6 | Sticky reset-cause flags |
| start_addr | output | 16 | Address where execution starts after reset |

## Verification
The hardest case to reach is a software flag write that lands in exactly the same cycle as a new event reaching the flag register. The event only arrives there after the synchroniser delay, so the bench drives a one-cycle software request and raises the clearing write two falling edges later, which lines the two up on the same edge. Another case that is hard to reach is a pin pulse while the pin enable is low. This is only honoured inside the power-up window, so the bench sends one such pulse before `core_rst` first falls and a second one after it, and checks that only the first leaves a flag.

// File: rtl/rcu_pkg.sv
// Shared constants for the reset cause unit: the number of sources and the
// bit position of each source in the flag vector. Software decodes these
// positions, so they are fixed.
package rcu_pkg;
    localparam int NUM_SRC = 6;
    localparam int F_EXT   = 0;
    localparam int F_POR   = 1;
    localparam int F_BOR   = 2;
    localparam int F_WDT   = 3;
    localparam int F_SW    = 4;
    localparam int F_BRK   = 5;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // flag value left by any power-class reset
    localparam src_vec_t PWR_FLAGS = src_vec_t'((1 << F_POR) | (1 << F_BOR));
endpackage

// File: rtl/rcu_sync.sv
// Multi-stage synchroniser for a vector of asynchronous request levels.
// Assumes every request pulse is long enough to be caught by the first stage.
// Output lags the input by STAGES clock edges.
module rcu_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // capture the raw request levels
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                // pass the value one stage further down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[gi] <= '0;
                    else        stage[gi] <= stage[gi-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/rcu_stretch.sv
// Reset stretcher and power-up phase tracker. Any active event reloads the hold
// counter. The internal reset is high while the counter is not zero. The
// power-up phase starts with a power-on event and ends when the counter first
// reaches zero. Assumes HOLD_CYCLES >= 1.
module rcu_stretch #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_evt,
    input  logic por_evt,
    output logic core_rst,
    output logic pwrup
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] cnt;

    // reload on any event, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= CW'(HOLD_CYCLES);
        else if (any_evt)       cnt <= CW'(HOLD_CYCLES);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    // power-up window: opened by power-on, closed at the first release
    always_ff @(posedge clk) begin
        if (!rst_n)             pwrup <= 1'b1;
        else if (por_evt)       pwrup <= 1'b1;
        else if (cnt == '0)     pwrup <= 1'b0;
    end

    assign core_rst = (cnt != '0);

    // R7
    evt_asserts_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |=> core_rst);
    // R7
    hold_expires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_evt && cnt == CW'(1)) |=> !core_rst);
    // R6
    pwrup_ends_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrup) |-> !core_rst);
endmodule

// File: rtl/rcu_flags.sv
// Sticky reset-cause flag register and last-cause-was-break tracker.
// evt carries synchronised, already gated events in flag bit order. Power-class
// events (power-on, watchdog) reload the flags. Other events are ORed in after
// the software write mask, so in the same cycle setting wins over clearing.
module rcu_flags
    import rcu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t evt,
    input  logic     wr_en,
    input  src_vec_t wr_data,
    output src_vec_t flags,
    output logic     brk_last
);
    logic     pwr_class;
    src_vec_t keep_mask;
    src_vec_t pwr_value;

    assign pwr_class = evt[F_POR] | evt[F_WDT];
    assign keep_mask = wr_en ? wr_data : '1;
    assign pwr_value = PWR_FLAGS | (evt & src_vec_t'(1 << F_WDT));

    // flag update: reload on power-class reset, else mask then set
    always_ff @(posedge clk) begin
        if (!rst_n)          flags <= PWR_FLAGS;
        else if (pwr_class)  flags <= pwr_value;
        else                 flags <= (flags & keep_mask) | evt;
    end

    // remember whether the most recent reset event was a serial break
    always_ff @(posedge clk) begin
        if (!rst_n)          brk_last <= 1'b0;
        else if (pwr_class)  brk_last <= 1'b0;
        else if (|evt)       brk_last <= evt[F_BRK];
    end

    // R2
    por_loads_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[F_POR] && !evt[F_WDT]) |=> (flags == PWR_FLAGS));
    // R4
    sw_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[F_SW] && !pwr_class) |=> flags[F_SW]);
    // R5
    no_rise_without_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> ((flags & ~$past(flags)) == '0));
endmodule

// File: rtl/reset_cause_unit.sv
// Top of the reset cause unit. Synchronises the six request inputs, gates the
// external pin by its enable or the power-up window, records the causes, stretches
// the internal reset and selects the start address. Assumes boot_stat, boot_vec,
// pin_rst_en and isp_force are quasi-static levels in the clock domain.
module reset_cause_unit
    import rcu_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16,
    parameter int VEC_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_rst_n_pin,
    input  logic                 pin_rst_en,
    input  logic                 por_req,
    input  logic                 bod_req,
    input  logic                 wdt_req,
    input  logic                 sw_req,
    input  logic                 brk_req,
    input  logic                 boot_stat,
    input  logic                 isp_force,
    input  logic [VEC_W-1:0]     boot_vec,
    input  logic                 flag_wr_en,
    input  logic [NUM_SRC-1:0]   flag_wr_data,
    output logic                 core_rst,
    output logic [NUM_SRC-1:0]   flags,
    output logic [2*VEC_W-1:0]   start_addr
);
    src_vec_t raw_req;
    src_vec_t sync_req;
    src_vec_t evt;
    logic     pwrup;
    logic     brk_last;
    logic     isp_seen;
    logic     use_boot;

    // requests in flag bit order; pin is active low
    always_comb begin
        raw_req         = '0;
        raw_req[F_EXT]  = ~ext_rst_n_pin;
        raw_req[F_POR]  = por_req;
        raw_req[F_BOR]  = bod_req;
        raw_req[F_WDT]  = wdt_req;
        raw_req[F_SW]   = sw_req;
        raw_req[F_BRK]  = brk_req;
    end

    rcu_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_req),
        .q     (sync_req)
    );

    // pin counts only when enabled or while powering up
    always_comb begin
        evt        = sync_req;
        evt[F_EXT] = sync_req[F_EXT] & (pin_rst_en | pwrup);
    end

    rcu_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_evt  (|evt),
        .por_evt  (evt[F_POR]),
        .core_rst (core_rst),
        .pwrup    (pwrup)
    );

    rcu_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .wr_en    (flag_wr_en),
        .wr_data  (flag_wr_data),
        .flags    (flags),
        .brk_last (brk_last)
    );

    // ISP latch: sampled at power-on, caught anywhere in the power-up window
    always_ff @(posedge clk) begin
        if (!rst_n)                 isp_seen <= 1'b0;
        else if (evt[F_POR])        isp_seen <= isp_force;
        else if (pwrup && isp_force) isp_seen <= 1'b1;
    end

    // start address: boot page or zero
    always_comb begin
        use_boot   = brk_last | boot_stat | isp_seen;
        start_addr = use_boot ? {boot_vec, {VEC_W{1'b0}}} : '0;
    end

    // R6
    pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_rst_en && !pwrup && !flags[F_EXT] && !flag_wr_en) |=> !flags[F_EXT]);
endmodule

// File: tb/reset_cause_unit_tb.sv
module reset_cause_unit_tb;
    localparam int HOLD = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b1, pin_en = 1'b0;
    logic        por = 1'b0, bod = 1'b0, wdt = 1'b0, sw = 1'b0, brk = 1'b0;
    logic        boot_stat = 1'b0, isp_force = 1'b1;
    logic [7:0]  boot_vec = 8'h3C;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_data = 6'h00;
    logic        core_rst;
    logic [5:0]  flags;
    logic [15:0] start_addr;

    int total = 0, bad = 0;
    bit done = 0, run_cmp = 0;

    always #2.5 clk = ~clk;

    reset_cause_unit #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .VEC_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n_pin(pin), .pin_rst_en(pin_en),
        .por_req(por), .bod_req(bod), .wdt_req(wdt), .sw_req(sw), .brk_req(brk),
        .boot_stat(boot_stat), .isp_force(isp_force), .boot_vec(boot_vec),
        .flag_wr_en(wr_en), .flag_wr_data(wr_data),
        .core_rst(core_rst), .flags(flags), .start_addr(start_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model, stepped on every rising edge
    logic [5:0] m_s1, m_s2, m_flags, e;
    int m_cnt;
    bit m_pwrup, m_isp, m_brk;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_flags = 6'h06; m_cnt = HOLD;
            m_pwrup = 1; m_isp = 0; m_brk = 0;
        end else begin
            e = m_s2;
            if (!(pin_en || m_pwrup)) e[0] = 1'b0;
            if (e[1]) m_isp = isp_force;
            else if (m_pwrup && isp_force) m_isp = 1;
            if (e[1] || e[3]) begin
                m_flags = 6'h06;
                if (e[3]) m_flags[3] = 1'b1;
                m_brk = 0;
            end else begin
                if (wr_en) m_flags = m_flags & wr_data;
                m_flags = m_flags | e;
                if (e != 0) m_brk = e[5];
            end
            if (e[1]) m_pwrup = 1;
            else if (m_cnt == 0) m_pwrup = 0;
            if (e != 0) m_cnt = HOLD;
            else if (m_cnt > 0) m_cnt--;
            m_s2 = m_s1;
            m_s1 = {brk, sw, wdt, bod, por, ~pin};
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (run_cmp && !done) begin
            chk(flags == m_flags, "model flags", {10'd0, flags}, {10'd0, m_flags});
            chk(core_rst == (m_cnt != 0), "model core_rst", {15'd0, core_rst}, {15'd0, 1'(m_cnt != 0)});
            chk(start_addr == ((m_brk || boot_stat || m_isp) ? {boot_vec, 8'h00} : 16'h0),
                "model start_addr", start_addr,
                (m_brk || boot_stat || m_isp) ? {boot_vec, 8'h00} : 16'h0);
        end
    end

    task automatic set_req(input int idx, input logic v);
        case (idx)
            0: pin = ~v;
            1: por = v;
            2: bod = v;
            3: wdt = v;
            4: sw  = v;
            default: brk = v;
        endcase
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); set_req(idx, 1'b1);
        @(negedge clk); set_req(idx, 1'b0);
    endtask

    task automatic settle();
        repeat (HOLD + 6) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            summary();
        end
    end

    initial begin
        int hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run_cmp = 1;
        @(negedge clk);
        chk(flags == 6'h06, "R2 reset flags", {10'd0, flags}, 16'h06);
        chk(core_rst == 1'b1, "R7 held after reset", {15'd0, core_rst}, 16'h1);
        // pin pulse inside power-up window, enable low: honoured
        pulse(0);
        @(negedge clk); isp_force = 1'b0;
        settle();
        chk(flags == 6'h07, "R6 pin in power-up R1 bit0", {10'd0, flags}, 16'h07);
        chk(start_addr == 16'h3C00, "R9 isp latched", start_addr, 16'h3C00);
        wr(6'h00);
        @(negedge clk);
        chk(flags == 6'h00, "R5 clear all", {10'd0, flags}, 16'h00);
        wr(6'h3F);
        @(negedge clk);
        chk(flags == 6'h00, "R5 write ones never sets", {10'd0, flags}, 16'h00);
        // pin after power-up with enable low: ignored
        pulse(0);
        settle();
        chk(flags == 6'h00, "R6 pin ignored flags", {10'd0, flags}, 16'h00);
        chk(core_rst == 1'b0, "R6 pin ignored rst", {15'd0, core_rst}, 16'h0);
        pin_en = 1'b1;
        pulse(0); settle();
        chk(flags == 6'h01, "R6 pin enabled", {10'd0, flags}, 16'h01);
        pulse(2); settle();
        chk(flags == 6'h05, "R4 brownout adds", {10'd0, flags}, 16'h05);
        pulse(4); settle();
        chk(flags == 6'h15, "R4 software adds", {10'd0, flags}, 16'h15);
        wr(6'h3E);
        @(negedge clk);
        chk(flags == 6'h14, "R5 clear one bit", {10'd0, flags}, 16'h14);
        pulse(1); settle();
        chk(flags == 6'h06, "R2 por_req reload", {10'd0, flags}, 16'h06);
        chk(start_addr == 16'h0000, "R8 zero start", start_addr, 16'h0000);
        pulse(5); settle();
        chk(flags == 6'h26, "R4 break adds", {10'd0, flags}, 16'h26);
        chk(start_addr == 16'h3C00, "R8 break boot page", start_addr, 16'h3C00);
        pulse(4); settle();
        chk(start_addr == 16'h0000, "R8 later sw ends break", start_addr, 16'h0000);
        boot_stat = 1'b1; boot_vec = 8'hA5;
        @(negedge clk);
        chk(start_addr == 16'hA500, "R8 boot status", start_addr, 16'hA500);
        boot_stat = 1'b0;
        pulse(3); settle();
        chk(flags == 6'h0E, "R3 watchdog reload", {10'd0, flags}, 16'h0E);
        // set beats clear in the same cycle
        wr(6'h00);
        @(negedge clk); sw = 1'b1;
        @(negedge clk); sw = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_data = 6'h00;
        chk(core_rst == 1'b0, "R7 not yet asserted", {15'd0, core_rst}, 16'h0);
        @(negedge clk); wr_en = 1'b0;
        chk(flags == 6'h10, "R5 set wins over clear", {10'd0, flags}, 16'h10);
        chk(core_rst == 1'b1, "R7 rise on third edge", {15'd0, core_rst}, 16'h1);
        hi = 1;
        while (core_rst && hi < 100) begin
            @(negedge clk);
            if (core_rst) hi++;
        end
        chk(hi == HOLD, "R7 hold length", 16'(hi), 16'(HOLD));
        settle();
        done = 1;
        summary();
    end
endmodule